// File: doc/BRIEF.md
# Processor Core Clock Controller

This block produces the clock of a processor core from one of several free-running sources and gates it on and off under software control. A small register, written and read through a single-cycle port in the crystal domain, picks the source, enables the core clock, requests a combined core-plus-bus shutdown, and holds a bypass control for an external duty-cycle adjuster. Source changes never put a runt pulse on the output: the old source is closed on its own falling edge, the output stays low, and only then is the new source opened on its falling edge. While that hand-over is under way, a read-only busy bit is set.

Stopping the core is deferred by a few crystal cycles so that the write that stops it can complete. If the stop write also sets the sleep bit, the register-bus clock output stops together with the core clock. A wake-up input brings both clocks back and returns the enable and sleep bits to their reset values. A plain stop, without the sleep bit, keeps the bus clock running and lasts until a later write sets the enable bit again or reset is applied.

Top module: `procClkCtrl`

## Requirements
- R1: After reset the register reads select=00, enable=1 and bypass=0, and within 25 crystal cycles the core clock runs from the crystal with busy at 0.
- R2: Register layout: bits [1:0] select, bit 2 core enable, bit 3 adjuster bypass, bit 4 sleep request (write-only, reads 0), bit 5 busy (read-only). Bits 31:6 read as 0 and ignore writes.
- R3: Select code 00 routes the crystal clock to the core clock output, code 01 routes the stretched clock input and code 11 routes the word-strobe clock input.
- R4: Busy reads 1 in the cycle after a write that changes the source, and returns to 0 within 25 crystal cycles once the new source drives the output.
- R5: With select code 10 the core clock output stays low and busy stays at 1.
- R6: The core clock output never carries a high or low pulse shorter than the shortest half period of the sources, and at most one source is gated through at a time.
- R7: Writing enable=0 with the sleep bit clear keeps the core clock running for at least 3 crystal cycles and stops it within 10. The bus clock keeps running, and the core clock stays stopped until enable=1 is written.
- R8: Writing enable=0 with the sleep bit set stops both the core clock and the bus clock output within 10 crystal cycles.
- R9: A wake-up pulse sets enable back to 1 and clears the sleep request within 10 crystal cycles, and both clocks run again.
- R10: The stretchDisable output follows register bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Asynchronous active-low reset |
| xtalClk | input | 1 | Crystal clock: register clock and source code 00 |
| strClk | input | 1 | Stretched clock source, code 01 |
| wsClk | input | 1 | Audio word-strobe clock source, code 11 |
| busClk | input | 1 | Free-running register-bus clock to be gated |
| regWr | input | 1 | Register write strobe, sampled on xtalClk |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational |
| wakeReq | input | 1 | Wake-up request, level, synchronised internally |
| coreClk | output | 1 | Gated core clock |
| busClkOut | output | 1 | Gated register-bus clock |
| stretchDisable | output | 1 | Bypass control for the external duty-cycle adjuster |

## Verification
Register contents change on the crystal edge that samples the write, so the bench compares readback against its model on the falling edge of every crystal cycle. Busy is due one crystal cycle after a source-changing write and must clear within 25 cycles, so it is sampled at exactly those two points. A stop takes effect after a 4-cycle countdown plus a two-flop synchroniser and a low-phase latch. The bench therefore counts edges in the first 3 cycles after the write (still running) and from cycle 10 onward (stopped). Frequency checks count output edges over a 40-cycle window that opens only after the 25-cycle settling time.

// File: rtl/procClkPkg.sv
package procClkPkg;
  localparam int SRC_N     = 4;
  localparam int SEL_W     = $clog2(SRC_N);
  localparam int UNDEF_SEL = 2;

  typedef struct packed {
    logic [SRC_N-1:0] srcReq;
    logic             busRun;
  } clkCtl_t;
endpackage

// File: rtl/procClkRegs.sv
module procClkRegs
  import procClkPkg::*;
#(
  parameter int STOP_DELAY = 4,
  parameter int DATA_W     = 32
) (
  input  logic              rstN,
  input  logic              xtalClk,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              wakeReq,
  input  logic [SRC_N-1:0]  gateSync,
  output clkCtl_t           ctl,
  output logic              stretchOff
);
  localparam int CNT_W = $clog2(STOP_DELAY + 1);

  logic [SEL_W-1:0] sel;
  logic             coreOn, sleepArm, coreRun, busRun, busy;
  logic [CNT_W-1:0] stopCnt;
  logic             wakeS1, wakeS2;

  always_ff @(posedge xtalClk or negedge rstN) begin
    if (!rstN) begin
      wakeS1 <= 1'b0;
      wakeS2 <= 1'b0;
    end else begin
      wakeS1 <= wakeReq;
      wakeS2 <= wakeS1;
    end
  end

  always_ff @(posedge xtalClk or negedge rstN) begin
    if (!rstN) begin
      sel        <= '0;
      coreOn     <= 1'b1;
      stretchOff <= 1'b0;
      sleepArm   <= 1'b0;
      stopCnt    <= '0;
      coreRun    <= 1'b1;
      busRun     <= 1'b1;
    end else if (wakeS2) begin
      coreOn   <= 1'b1;
      sleepArm <= 1'b0;
      stopCnt  <= '0;
      coreRun  <= 1'b1;
      busRun   <= 1'b1;
    end else begin
      if (stopCnt != '0) begin
        stopCnt <= stopCnt - 1'b1;
        if (stopCnt == CNT_W'(1)) begin
          coreRun <= 1'b0;
          if (sleepArm) busRun <= 1'b0;
        end
      end
      if (regWr) begin
        sel        <= regWdata[SEL_W-1:0];
        stretchOff <= regWdata[3];
        if (regWdata[2]) begin
          coreOn   <= 1'b1;
          sleepArm <= 1'b0;
          stopCnt  <= '0;
          coreRun  <= 1'b1;
          busRun   <= 1'b1;
        end else if (coreOn) begin
          coreOn   <= 1'b0;
          sleepArm <= regWdata[4];
          stopCnt  <= CNT_W'(STOP_DELAY);
        end
      end
    end
  end

  always_comb begin
    ctl.srcReq = '0;
    if (coreRun && sel != SEL_W'(UNDEF_SEL)) ctl.srcReq = SRC_N'(1) << sel;
    ctl.busRun = busRun;
    busy = coreRun & ((sel == SEL_W'(UNDEF_SEL)) | (ctl.srcReq != gateSync));
    regRdata = '0;
    regRdata[SEL_W-1:0] = sel;
    regRdata[2] = coreOn;
    regRdata[3] = stretchOff;
    regRdata[5] = busy;
  end

  AST_STOP_DEFER: assert property (@(posedge xtalClk) disable iff (!rstN)
    (regWr && !regWdata[2] && coreOn && !wakeS2) |=> coreRun); // R7
  AST_BUS_COUPLED: assert property (@(posedge xtalClk) disable iff (!rstN)
    !busRun |-> !coreRun); // R8
  AST_WAKE_RESTORE: assert property (@(posedge xtalClk) disable iff (!rstN)
    wakeS2 |=> (coreOn && busRun && coreRun)); // R9
  AST_REQ_SINGLE: assert property (@(posedge xtalClk) disable iff (!rstN)
    $onehot0(ctl.srcReq)); // R6
endmodule

// File: rtl/procClkGate.sv
module procClkGate
  import procClkPkg::*;
(
  input  logic             rstN,
  input  logic             xtalClk,
  input  logic [SRC_N-1:0] srcClk,
  input  logic             busClk,
  input  clkCtl_t          ctl,
  output logic             coreClk,
  output logic [SRC_N-1:0] gateSync,
  output logic             busClkOut
);
  logic [SRC_N-1:0] laneS1, laneS2, gateEn, laneActive;
  assign laneActive = laneS1 | laneS2 | gateEn;

  for (genvar gi = 0; gi < SRC_N; gi++) begin : g_lane
    if (gi == UNDEF_SEL) begin : g_none
      assign laneS1[gi] = 1'b0;
      assign laneS2[gi] = 1'b0;
      assign gateEn[gi] = 1'b0;
    end else begin : g_src
      logic s1q, s2q, enQ, reqIn;
      assign reqIn = ctl.srcReq[gi] & ~|(laneActive & ~(SRC_N'(1) << gi));
      always_ff @(posedge srcClk[gi] or negedge rstN) begin
        if (!rstN) begin
          s1q <= 1'b0;
          s2q <= 1'b0;
        end else begin
          s1q <= reqIn;
          s2q <= s1q;
        end
      end
      always_latch begin
        if (!rstN) enQ = 1'b0;
        else if (!srcClk[gi]) enQ = s2q;
      end
      assign laneS1[gi] = s1q;
      assign laneS2[gi] = s2q;
      assign gateEn[gi] = enQ;
    end
  end

  assign coreClk = |(srcClk & gateEn);

  logic [SRC_N-1:0] gateMeta;
  always_ff @(posedge xtalClk or negedge rstN) begin
    if (!rstN) begin
      gateMeta <= '0;
      gateSync <= '0;
    end else begin
      gateMeta <= gateEn;
      gateSync <= gateMeta;
    end
  end

  logic busS1, busS2, busEn;
  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      busS1 <= 1'b1;
      busS2 <= 1'b1;
    end else begin
      busS1 <= ctl.busRun;
      busS2 <= busS1;
    end
  end
  always_latch begin
    if (!rstN) busEn = 1'b1;
    else if (!busClk) busEn = busS2;
  end
  assign busClkOut = busClk & busEn;

  AST_ONE_GATE: assert property (@(posedge xtalClk) disable iff (!rstN)
    $onehot0(gateSync)); // R6
endmodule

// File: rtl/procClkCtrl.sv
module procClkCtrl
  import procClkPkg::*;
#(
  parameter int STOP_DELAY = 4
) (
  input  logic        rstN,
  input  logic        xtalClk,
  input  logic        strClk,
  input  logic        wsClk,
  input  logic        busClk,
  input  logic        regWr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        wakeReq,
  output logic        coreClk,
  output logic        busClkOut,
  output logic        stretchDisable
);
  clkCtl_t          ctl;
  logic [SRC_N-1:0] gateSync;
  logic [SRC_N-1:0] srcClk;

  assign srcClk = {wsClk, 1'b0, strClk, xtalClk};

  procClkRegs #(.STOP_DELAY(STOP_DELAY), .DATA_W(32)) regs_i (
    .rstN(rstN), .xtalClk(xtalClk), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .wakeReq(wakeReq), .gateSync(gateSync),
    .ctl(ctl), .stretchOff(stretchDisable)
  );

  procClkGate gate_i (
    .rstN(rstN), .xtalClk(xtalClk), .srcClk(srcClk), .busClk(busClk),
    .ctl(ctl), .coreClk(coreClk), .gateSync(gateSync), .busClkOut(busClkOut)
  );
endmodule

// File: tb/procClkCtrl_tb.sv
`timescale 1ns/1ps
module procClkCtrl_tb_top;
  logic rstN = 1'b0, xtalClk = 1'b0, strClk = 1'b0, wsClk = 1'b0, busClk = 1'b0;
  logic regWr = 1'b0, wakeReq = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic coreClk, busClkOut, stretchDisable;

  int checks = 0, fails = 0;
  int coreEdges = 0, busEdges = 0;
  int narrowPulses = 0;
  bit cmpOn = 1'b0;
  logic [1:0] mSel;
  logic mOn, mStr;
  realtime lastChange = 0.0;

  always #5.0  xtalClk = ~xtalClk;
  always #3.5  strClk  = ~strClk;
  always #11.5 wsClk   = ~wsClk;
  always #3.0  busClk  = ~busClk;

  procClkCtrl dut_i (
    .rstN(rstN), .xtalClk(xtalClk), .strClk(strClk), .wsClk(wsClk), .busClk(busClk),
    .regWr(regWr), .regWdata(regWdata), .regRdata(regRdata), .wakeReq(wakeReq),
    .coreClk(coreClk), .busClkOut(busClkOut), .stretchDisable(stretchDisable)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge coreClk) coreEdges++;
  always @(posedge busClkOut) busEdges++;

  // R6: pulse width monitor on the core clock
  always @(coreClk) begin
    if (rstN && lastChange > 0.0 && ($realtime - lastChange) < 3.0) narrowPulses++;
    lastChange = $realtime;
  end

  // reference register model
  always @(posedge xtalClk) begin
    if (!rstN) begin
      mSel <= 2'b00; mOn <= 1'b1; mStr <= 1'b0;
    end else if (regWr) begin
      mSel <= regWdata[1:0];
      mStr <= regWdata[3];
      mOn  <= regWdata[2];
    end
  end

  always @(negedge xtalClk) begin
    if (cmpOn) begin
      check(regRdata[4:0] == {1'b0, mStr, mOn, mSel}, "R2 readback",
            int'(regRdata[4:0]), int'({1'b0, mStr, mOn, mSel}));
      check(regRdata[31:6] == '0, "R2 reserved", int'(regRdata[31:6]), 0);
      check(stretchDisable == mStr, "R10 bypass pin", int'(stretchDisable), int'(mStr));
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge xtalClk);
  endtask

  task automatic regWrite(input logic [31:0] d);
    @(negedge xtalClk);
    regWr = 1'b1; regWdata = d;
    @(negedge xtalClk);
    regWr = 1'b0; regWdata = '0;
  endtask

  task automatic countEdges(input int n, output int core, output int bus);
    int c0, b0;
    c0 = coreEdges; b0 = busEdges;
    cyc(n);
    core = coreEdges - c0;
    bus = busEdges - b0;
  endtask

  task automatic freqCheck(input string req, input int expCore, input int tol);
    int c, b;
    countEdges(40, c, b);
    check(c >= expCore - tol && c <= expCore + tol, req, c, expCore);
  endtask

  initial begin
    #100000;
    fails++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int c, b;
    cyc(10);
    rstN = 1'b1;
    cyc(1);
    cmpOn = 1'b1;
    check(regRdata[5:0] == 6'b000100 || regRdata[5:0] == 6'b100100, "R1 reset value",
          int'(regRdata[4:0]), 4);
    cyc(25);
    check(regRdata[5] == 1'b0, "R1 busy settled", int'(regRdata[5]), 0);
    freqCheck("R1 R3 crystal source", 40, 2);

    // stretched source
    regWrite(32'h0000_0005);
    check(regRdata[5] == 1'b1, "R4 busy after switch", int'(regRdata[5]), 1);
    cyc(25);
    check(regRdata[5] == 1'b0, "R4 busy cleared", int'(regRdata[5]), 0);
    freqCheck("R3 stretched source", 57, 3);

    // word-strobe source, reserved bits and bypass written with ones
    regWrite(32'hFFFF_FFCF);
    check(regRdata[5] == 1'b1, "R4 busy after switch", int'(regRdata[5]), 1);
    check(stretchDisable == 1'b1, "R10 bypass set", int'(stretchDisable), 1);
    cyc(25);
    check(regRdata[5] == 1'b0, "R4 busy cleared", int'(regRdata[5]), 0);
    freqCheck("R3 word-strobe source", 17, 2);

    // undefined code
    regWrite(32'h0000_0006);
    cyc(25);
    check(regRdata[5] == 1'b1, "R5 busy held", int'(regRdata[5]), 1);
    freqCheck("R5 output held low", 0, 0);
    check(coreClk == 1'b0, "R5 level low", int'(coreClk), 0);

    regWrite(32'h0000_0004);
    cyc(25);
    check(regRdata[5] == 1'b0, "R4 busy cleared", int'(regRdata[5]), 0);
    freqCheck("R3 back to crystal", 40, 2);

    // plain stop
    regWrite(32'h0000_0000);
    countEdges(2, c, b);
    check(c >= 2, "R7 still running after write", c, 2);
    cyc(7);
    countEdges(30, c, b);
    check(c == 0, "R7 core stopped", c, 0);
    check(b >= 45, "R7 bus still running", b, 50);
    cyc(20);
    check(coreEdges >= 0 && coreClk == 1'b0, "R7 stays stopped", int'(coreClk), 0);
    regWrite(32'h0000_0004);
    cyc(25);
    freqCheck("R7 restart by write", 40, 2);

    // deep sleep
    regWrite(32'h0000_0010);
    check(regRdata[4] == 1'b0, "R2 sleep bit reads zero", int'(regRdata[4]), 0);
    cyc(9);
    countEdges(30, c, b);
    check(c == 0, "R8 core stopped", c, 0);
    check(b == 0, "R8 bus stopped", b, 0);

    // wake-up
    cmpOn = 1'b0;
    @(negedge xtalClk); wakeReq = 1'b1;
    cyc(2); wakeReq = 1'b0;
    cyc(8);
    check(regRdata[2] == 1'b1, "R9 enable restored", int'(regRdata[2]), 1);
    check(regRdata[4] == 1'b0, "R9 sleep cleared", int'(regRdata[4]), 0);
    mOn = 1'b1;
    cmpOn = 1'b1;
    cyc(25);
    countEdges(40, c, b);
    check(c >= 38 && c <= 42, "R9 core clock back", c, 40);
    check(b >= 63 && b <= 70, "R9 bus clock back", b, 66);

    check(narrowPulses == 0, "R6 no narrow pulses", narrowPulses, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule